// File: doc/BRIEF.md
# Two-Phase Interleaved Cascaded Delta-Sigma Modulator

This block is the digital core of an oversampled current-steering DAC. Every clock cycle it accepts two 12-bit unsigned samples, an even-phase sample and an odd-phase sample. It returns two 4-bit output codes, which a following stage multiplexes onto an output running at twice the clock rate. Because both phases are computed in the same cycle, the logic runs at half the output sample rate, and one clock drives both the logic and the output multiplexer.

Each sample is split in two. The top 3 bits pass through as a coarse code. The low 9 bits drive two cascaded first-order error-feedback stages. Each stage is a 9-bit wrapping accumulator, and its carry-out serves as a 1-bit quantizer. The second stage integrates the updated state of the first stage. The outputs of both stages are recombined so that the quantization error of the first stage cancels. The odd-phase update of each accumulator is formed directly from the previous state plus both phase inputs, so it does not wait for the even-phase result. Each registered code is also expanded into a 15-bit thermometer word that drives unit current elements.

Top module: `mash_il_mod`

## Requirements
- R1: A synchronous active-high `rst` clears both accumulators, the stored odd-phase carry and both output codes. In the cycle after a reset edge, both codes and both thermometer words read 0.
- R2: Bits [11:9] of each sample are added to that phase's output code at a weight of one code step. Bits [8:0] feed the first accumulator.
- R3: Each stage is a 9-bit accumulator that wraps modulo 512. Its carry-out is 1 exactly when the unwrapped sum reaches 512. The even phase is applied to the state first, and the odd phase is applied after it.
- R4: The odd-phase carry and the odd-phase state are equal to the values produced by adding the odd input to the even-phase result in sequence. Both are derived from one sum: state + even input + odd input.
- R5: The second stage integrates the updated first-stage state (the residue) of each phase, in the same phase order.
- R6: Each phase's code is coarse + c1[n] + c2[n] − c2[n−1]. For the even phase, c2[n−1] is the odd-phase second-stage carry of the previous cycle. For the odd phase, it is the even-phase carry of the same cycle.
- R7: A recombined value below 0 is clamped to 0. A value above 15 is clamped to 15.
- R8: Thermometer bit i (i = 0..14) is 1 exactly when the code is greater than i.
- R9: The codes for the samples presented before a clock edge appear at the outputs right after that edge, with a latency of one cycle.
- R10: With a constant input and no clamping, the sum of the output codes over 8192 samples after reset equals 8192·x/512 within 8192/4096 codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at half the output sample rate |
| rst | input | 1 | Synchronous active-high reset |
| sampleEven | input | 12 | Even-phase input sample |
| sampleOdd | input | 12 | Odd-phase input sample |
| codeEven | output | 4 | Registered even-phase code, placed first on the output |
| codeOdd | output | 4 | Registered odd-phase code |
| thermEven | output | 15 | Thermometer word for codeEven |
| thermOdd | output | 15 | Thermometer word for codeOdd |

## Verification
The bench runs a sequential single-rate model one sample at a time and compares every code and thermometer word against it. A look-ahead that chained the wrong carry, or that lost the second carry when both fine inputs push the sum past 1024, would diverge from the model on random inputs. Pairs with the even input at 511 and the odd input at 0 are aimed at phase ordering and the residue feeding stage two; swapped phases or a stage two fed from the pre-update state would misplace carries. Small inputs with a coarse value of 0 force negative recombined values, so a missing clamp would wrap to 15. A reset during traffic, a step from 0 to full scale, and a long constant run expose a stale stored carry, a wrong latency, or a bias in the noise cancellation.

// File: rtl/mash_pkg.sv
package mash_pkg;
  typedef struct packed {
    logic clrState;
    logic advance;
  } ctrlStrobes_t;
endpackage

// File: rtl/mash_ctrl.sv
module mash_ctrl
  import mash_pkg::*;
(
  input  logic         rst,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.clrState = rst;
    strobes.advance  = ~rst;
  end
endmodule

// File: rtl/mash_stage.sv
module mash_stage
  import mash_pkg::*;
#(
  parameter int W = 9
) (
  input  logic         clk,
  input  ctrlStrobes_t strobes,
  input  logic [W-1:0] inE,
  input  logic [W-1:0] inO,
  output logic         carryE,
  output logic         carryO,
  output logic [W-1:0] residE,
  output logic [W-1:0] residO
);
  logic [W-1:0] acc;
  logic [W:0]   sumE;
  logic [W+1:0] sumO;
  logic [1:0]   oddCnt;
  logic [W:0]   seqOdd;

  always_comb begin
    sumE   = {1'b0, acc} + {1'b0, inE};
    sumO   = {2'b00, acc} + {2'b00, inE} + {2'b00, inO};
    oddCnt = sumO[W+1:W] - {1'b0, sumE[W]};
    carryE = sumE[W];
    carryO = oddCnt[0];
    residE = sumE[W-1:0];
    residO = sumO[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (strobes.clrState) acc <= '0;
    else if (strobes.advance) acc <= residO;
  end

  // sequential reference for the odd phase, used only by the check below
  assign seqOdd = {1'b0, residE} + {1'b0, inO};

  // R4
  lookahead_eq_chk: assert property (@(posedge clk) disable iff (strobes.clrState)
    (carryO == seqOdd[W]) && (residO == seqOdd[W-1:0]));

  // R3
  wrap_carry_chk: assert property (@(posedge clk) disable iff (strobes.clrState)
    carryE == (residE < inE));
endmodule

// File: rtl/mash_therm.sv
module mash_therm #(
  parameter int CODE_W = 4,
  localparam int ELEM = (1 << CODE_W) - 1
) (
  input  logic [CODE_W-1:0] code,
  output logic [ELEM-1:0]   therm
);
  for (genvar i = 0; i < ELEM; i++) begin : g_bit
    assign therm[i] = (int'(code) > i);
  end
endmodule

// File: rtl/mash_datapath.sv
module mash_datapath
  import mash_pkg::*;
#(
  parameter int IN_W   = 12,
  parameter int FINE_W = 9,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  ctrlStrobes_t      strobes,
  input  logic [IN_W-1:0]   xE,
  input  logic [IN_W-1:0]   xO,
  output logic [CODE_W-1:0] codeE,
  output logic [CODE_W-1:0] codeO
);
  localparam int COARSE_W = IN_W - FINE_W;
  localparam int SUM_W    = CODE_W + 2;
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int NSTAGE   = 2;

  logic [COARSE_W-1:0] coarseE, coarseO;
  logic [FINE_W-1:0]   stInE  [NSTAGE];
  logic [FINE_W-1:0]   stInO  [NSTAGE];
  logic [FINE_W-1:0]   resE   [NSTAGE];
  logic [FINE_W-1:0]   resO   [NSTAGE];
  logic                carE   [NSTAGE];
  logic                carO   [NSTAGE];
  logic                c2Prev;
  logic [CODE_W-1:0]   nextE, nextO;

  assign coarseE = xE[IN_W-1:FINE_W];
  assign coarseO = xO[IN_W-1:FINE_W];

  assign stInE[0] = xE[FINE_W-1:0];
  assign stInO[0] = xO[FINE_W-1:0];

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    if (s > 0) begin : g_link
      assign stInE[s] = resE[s-1];
      assign stInO[s] = resO[s-1];
    end
    mash_stage #(.W(FINE_W)) u_stage (
      .clk    (clk),
      .strobes(strobes),
      .inE    (stInE[s]),
      .inO    (stInO[s]),
      .carryE (carE[s]),
      .carryO (carO[s]),
      .residE (resE[s]),
      .residO (resO[s])
    );
  end

  function automatic logic [CODE_W-1:0] recombine(
    input logic [COARSE_W-1:0] crs,
    input logic                c1,
    input logic                c2,
    input logic                c2Old
  );
    logic [SUM_W-1:0] pos;
    pos = SUM_W'(crs) + SUM_W'(c1) + SUM_W'(c2);
    if (pos < SUM_W'(c2Old)) return '0;
    pos = pos - SUM_W'(c2Old);
    if (pos > SUM_W'(CODE_MAX)) return CODE_W'(CODE_MAX);
    return pos[CODE_W-1:0];
  endfunction

  always_comb begin
    nextE = recombine(coarseE, carE[0], carE[NSTAGE-1], c2Prev);
    nextO = recombine(coarseO, carO[0], carO[NSTAGE-1], carE[NSTAGE-1]);
  end

  always_ff @(posedge clk) begin
    if (strobes.clrState) begin
      codeE  <= '0;
      codeO  <= '0;
      c2Prev <= 1'b0;
    end else if (strobes.advance) begin
      codeE  <= nextE;
      codeO  <= nextO;
      c2Prev <= carO[NSTAGE-1];
    end
  end

  // R6
  recomb_range_chk: assert property (@(posedge clk) disable iff (strobes.clrState)
    1'b1 |=> (int'(codeE) <= int'($past(coarseE)) + 2) &&
             (int'(codeO) <= int'($past(coarseO)) + 2) &&
             (int'(codeE) + 1 >= int'($past(coarseE))) &&
             (int'(codeO) + 1 >= int'($past(coarseO))));
endmodule

// File: rtl/mash_il_mod.sv
module mash_il_mod
  import mash_pkg::*;
#(
  parameter int IN_W   = 12,
  parameter int FINE_W = 9,
  parameter int CODE_W = 4,
  localparam int ELEM  = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IN_W-1:0]   sampleEven,
  input  logic [IN_W-1:0]   sampleOdd,
  output logic [CODE_W-1:0] codeEven,
  output logic [CODE_W-1:0] codeOdd,
  output logic [ELEM-1:0]   thermEven,
  output logic [ELEM-1:0]   thermOdd
);
  ctrlStrobes_t strobes;

  mash_ctrl u_ctrl (
    .rst    (rst),
    .strobes(strobes)
  );

  mash_datapath #(.IN_W(IN_W), .FINE_W(FINE_W), .CODE_W(CODE_W)) u_dp (
    .clk    (clk),
    .strobes(strobes),
    .xE     (sampleEven),
    .xO     (sampleOdd),
    .codeE  (codeEven),
    .codeO  (codeOdd)
  );

  mash_therm #(.CODE_W(CODE_W)) u_thermE (.code(codeEven), .therm(thermEven));
  mash_therm #(.CODE_W(CODE_W)) u_thermO (.code(codeOdd),  .therm(thermOdd));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (codeEven == '0) && (codeOdd == '0));

  // R8
  therm_count_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(thermEven) == int'(codeEven)) &&
    ($countones(thermOdd) == int'(codeOdd)) &&
    (((thermEven + 1'b1) & thermEven) == '0) &&
    (((thermOdd + 1'b1) & thermOdd) == '0));
endmodule

// File: tb/tb_mash_il_mod.sv
module tb_mash_il_mod;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] sampleEven = '0;
  logic [11:0] sampleOdd = '0;
  logic [3:0]  codeEven, codeOdd;
  logic [14:0] thermEven, thermOdd;

  int    nChecks = 0;
  int    nFails = 0;
  string curReq = "R1";
  int    expQ[$];
  int    rA1 = 0, rA2 = 0, rC2 = 0, clampHits = 0;
  longint sumAct = 0;

  always #5 clk = ~clk;

  mash_il_mod dut (
    .clk(clk), .rst(rst), .sampleEven(sampleEven), .sampleOdd(sampleOdd),
    .codeEven(codeEven), .codeOdd(codeOdd), .thermEven(thermEven), .thermOdd(thermOdd)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // sequential one-sample-at-a-time model
  task automatic refStep(input logic [11:0] x, output int y);
    int t, u, c1, c2;
    t = rA1 + int'(x[8:0]);
    c1 = (t >= 512) ? 1 : 0;
    rA1 = t % 512;
    u = rA2 + rA1;
    c2 = (u >= 512) ? 1 : 0;
    rA2 = u % 512;
    y = int'(x[11:9]) + c1 + c2 - rC2;
    if (y < 0) begin y = 0; clampHits++; end
    if (y > 15) y = 15;
    rC2 = c2;
  endtask

  task automatic drive(input logic [11:0] xe, input logic [11:0] xo, input bit mean);
    int ye, yo;
    @(negedge clk);
    rst = 1'b0;
    sampleEven = xe;
    sampleOdd = xo;
    refStep(xe, ye);
    refStep(xo, yo);
    expQ.push_back({23'd0, mean, ye[3:0], yo[3:0]});
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    rA1 = 0; rA2 = 0; rC2 = 0;
    @(posedge clk);
    #3;
    check("R1", "codeEven after reset", int'(codeEven), 0);
    check("R1", "codeOdd after reset", int'(codeOdd), 0);
    check("R1", "thermEven after reset", int'(thermEven), 0);
    check("R1", "thermOdd after reset", int'(thermOdd), 0);
  endtask

  // monitor: pops one expected pair per cycle
  always @(posedge clk) begin
    int e, ye, yo;
    #2;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      ye = (e >> 4) & 15;
      yo = e & 15;
      check(curReq, "codeEven", int'(codeEven), ye);
      check(curReq, "codeOdd", int'(codeOdd), yo);
      check("R8", "thermEven", int'(thermEven), (1 << ye) - 1);
      check("R8", "thermOdd", int'(thermOdd), (1 << yo) - 1);
      if (e[8]) sumAct += longint'(codeEven) + longint'(codeOdd);
    end
  end

  initial begin
    #1_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    longint err;
    repeat (3) @(negedge clk);
    doReset();

    curReq = "R2";
    for (int k = 0; k < 8; k++) drive(12'(k << 9), 12'((k << 9) | 9'h0A5), 1'b0);
    for (int i = 0; i < 40; i++) drive(12'($urandom), 12'($urandom), 1'b0);

    curReq = "R3";
    for (int i = 0; i < 40; i++) drive(12'd256, 12'd100, 1'b0);
    for (int i = 0; i < 20; i++) drive(12'd511, 12'd511, 1'b0);

    curReq = "R4";
    for (int i = 0; i < 200; i++) drive(12'($urandom), 12'($urandom), 1'b0);

    curReq = "R5";
    for (int i = 0; i < 60; i++) drive(12'd511, 12'd0, 1'b0);
    for (int i = 0; i < 60; i++) drive(12'd0, 12'd511, 1'b0);

    curReq = "R7";
    for (int i = 0; i < 200; i++) drive(12'($urandom_range(0, 300)), 12'($urandom_range(0, 300)), 1'b0);
    for (int i = 0; i < 20; i++) drive(12'd4095, 12'd4095, 1'b0);

    curReq = "R9";
    drive(12'd0, 12'd0, 1'b0);
    drive(12'd4095, 12'd0, 1'b0);
    drive(12'd0, 12'd4095, 1'b0);

    curReq = "R6";
    for (int i = 0; i < 100; i++) drive(12'($urandom), 12'($urandom), 1'b0);

    @(negedge clk);
    nChecks++;
    if (clampHits == 0) begin
      nFails++;
      $display("FAIL R7 clamp stimulus: actual %0d expected >0", clampHits);
    end

    // reset in the middle of traffic, then resume
    doReset();
    curReq = "R1";
    for (int i = 0; i < 30; i++) drive(12'($urandom), 12'($urandom), 1'b0);

    // long constant run for the average
    doReset();
    sumAct = 0;
    curReq = "R10";
    for (int i = 0; i < 4096; i++) drive(12'd1443, 12'd1443, 1'b1);
    repeat (3) @(negedge clk);
    err = sumAct * 512 - longint'(8192) * 1443;
    if (err < 0) err = -err;
    nChecks++;
    if (err > 1024) begin
      nFails++;
      $display("FAIL R10 mean: actual %0d expected %0d (x512, tol 1024)",
               sumAct * 512, longint'(8192) * 1443);
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule